// File: doc/BRIEF.md
# PLL Multiplier Parameter Search Engine

This block finds a PLL setting that turns a fixed 24 MHz reference into a requested output frequency. A target frequency in kHz and a variant select are captured on a start pulse. The engine then tries power-of-two output dividers from the largest down. For each divider it computes the VCO frequency, an integer multiplier and a truncated fraction. It stops at the first candidate that falls inside the empirical limits of the selected variant.

The two variants differ in their parent frequency and fraction width. Variant A (mode = 0) has a halving stage in front of the multiplier, so its effective parent is 48000 kHz and its fraction has 12 bits (FRAC_MAX 4096). Variant B (mode = 1) uses the 24000 kHz reference directly and has a 10-bit fraction (FRAC_MAX 1024). Every division runs through one shared bit-serial divider. When a setting is found, the block also reports how the divider is spread over three cascaded stages, together with a 2-bit register code for each stage.

Top module: `pll_search_engine`

## Requirements
- R1: After reset, done = 0, found = 0, mult = 0, frac = 0 and od = 0.
- R2: A start pulse while idle captures mode and target_khz, and busy is high from the next cycle until done. done is a single-cycle pulse. A start while busy has no effect on the search that is running or on its result.
- R3: Output dividers are tried in the order 16, 8, 4, 2. The reported od is the first one whose candidate passes validation.
- R4: For each divider, vco = target_khz × od and M = floor(vco / parent), with parent = 48000 when mode = 0 and 24000 when mode = 1. A divider whose M is 0 is skipped.
- R5: FRAC = 0 when vco is an exact multiple of parent. Otherwise FRAC = floor(vco × FMAX / parent) − M × FMAX, limited to FMAX − 1. If M × FMAX exceeds the scaled value, the candidate's FRAC is FMAX. FMAX is 4096 for mode 0 and 1024 for mode 1.
- R6: A candidate passes only when FRAC < FMAX and M lies in 53..123 (mode 0) or in 106..247 (mode 1). On success, found = 1, mult = M and frac = FRAC.
- R7: If no divider passes, done pulses with found = 0, mult = 0, frac = 0 and od = 0.
- R8: The stage split has od3 = 1 always. For od < 4 it gives od1 = 2 and od2 = 1. Otherwise it gives od2 = od / 4 and od1 = od / od2.
- R9: Each stage value maps to a 2-bit code: 1→0, 2→1, 4→2, 8→3, and any other value →0. The codes appear on od1_code, od2_code and od3_code.
- R10: Results change only in the cycle done is high and hold until the next search completes. mode and target_khz are ignored outside a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a search when idle |
| mode | input | 1 | 0 = halved-parent variant, 1 = direct variant |
| target_khz | input | TW (24) | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A valid setting was found |
| mult | output | MW (8) | Integer multiplier |
| frac | output | 12 | Fractional multiplier part |
| od | output | ODW (5) | Selected output divider |
| od1 | output | ODW (5) | First stage divider |
| od2 | output | ODW (5) | Second stage divider |
| od3 | output | ODW (5) | Third stage divider |
| od1_code | output | 2 | Code of od1 |
| od2_code | output | 2 | Code of od2 |
| od3_code | output | 2 | Code of od3 |

## Verification
The latency depends on the data. Each divider step costs one divide of about 41 cycles, or two when the fraction is needed, so a result can arrive anywhere from about 45 to about 370 cycles after start. The bench does not predict that count. It polls done on the falling edge and compares every result output in the cycle done is high, because mult, frac, od and found are registered in the same edge as done. The stage split and codes are combinational from od, so they are checked in that same sample. Stability is then checked on later falling edges, before the next start.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    parameter int REF_KHZ   = 24000;
    parameter int FA_A      = 12;
    parameter int FA_B      = 10;
    parameter int M_MIN_A   = 53;
    parameter int M_MAX_A   = 123;
    parameter int M_MIN_B   = 106;
    parameter int M_MAX_B   = 247;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH_M,
        S_WAIT_M,
        S_LAUNCH_F,
        S_WAIT_F,
        S_JUDGE
    } srch_st_e;

    function automatic logic [1:0] stage_code(input logic [7:0] v);
        case (v)
            8'd1:    stage_code = 2'd0;
            8'd2:    stage_code = 2'd1;
            8'd4:    stage_code = 2'd2;
            8'd8:    stage_code = 2'd3;
            default: stage_code = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int N  = 40,
    parameter int D  = 16,
    localparam int CW = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [D-1:0] remainder
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [N-1:0]  quo;
        logic [D-1:0]  rem;
    } div_t;

    div_t q, d;
    logic [D:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[N-1]};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(N);
            d.quo  = dividend;
            d.rem  = '0;
        end else if (q.busy) begin
            if (trial >= {1'b0, divisor}) begin
                d.rem = D'(trial - {1'b0, divisor});
                d.quo = {q.quo[N-2:0], 1'b1};
            end else begin
                d.rem = trial[D-1:0];
                d.quo = {q.quo[N-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign quotient  = q.quo;
    assign remainder = q.rem;

    // R4: a quotient is only delivered at the end of a running division
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R4: the remainder handed on is always below the divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < divisor));

endmodule

// File: rtl/pll_od_split.sv
module pll_od_split #(
    parameter int ODW = 5
) (
    input  logic [ODW-1:0] od,
    output logic [ODW-1:0] od1,
    output logic [ODW-1:0] od2,
    output logic [ODW-1:0] od3,
    output logic [5:0]     codes
);

    import pll_search_pkg::*;

    logic [ODW-1:0] stage [3];

    always_comb begin
        od3 = ODW'(1);
        if (od < ODW'(4)) begin
            od1 = ODW'(2);
            od2 = ODW'(1);
        end else begin
            od2 = od >> 2;
            od1 = od / od2;
        end
    end

    assign stage[0] = od1;
    assign stage[1] = od2;
    assign stage[2] = od3;

    for (genvar g = 0; g < 3; g++) begin : g_code
        assign codes[2*g +: 2] = stage_code(8'(stage[g]));
    end

endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine #(
    parameter int TW     = 24,
    parameter int MW     = 8,
    parameter int OD_MAX = 16,
    parameter int OD_MIN = 2,
    localparam int FA    = pll_search_pkg::FA_A,
    localparam int ODS   = $clog2(OD_MAX),
    localparam int SHMIN = $clog2(OD_MIN),
    localparam int SHW   = $clog2(ODS + 1),
    localparam int ODW   = ODS + 1,
    localparam int VW    = TW + ODS,
    localparam int SW    = VW + FA,
    localparam int DW    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           mode,
    input  logic [TW-1:0]  target_khz,
    output logic           busy,
    output logic           done,
    output logic           found,
    output logic [MW-1:0]  mult,
    output logic [FA-1:0]  frac,
    output logic [ODW-1:0] od,
    output logic [ODW-1:0] od1,
    output logic [ODW-1:0] od2,
    output logic [ODW-1:0] od3,
    output logic [1:0]     od1_code,
    output logic [1:0]     od2_code,
    output logic [1:0]     od3_code
);

    import pll_search_pkg::*;

    typedef struct packed {
        srch_st_e       st;
        logic           mode;
        logic [TW-1:0]  tgt;
        logic [SHW-1:0] sh;
        logic [VW-1:0]  vco;
        logic [VW-1:0]  mc;
        logic [FA:0]    fc;
        logic           done;
        logic           found;
        logic [MW-1:0]  m;
        logic [FA-1:0]  fr;
        logic [ODW-1:0] od;
    } eng_t;

    eng_t q, d;

    logic [DW-1:0] parent;
    logic [3:0]    fsh;
    logic [FA:0]   fmax;
    logic [VW-1:0] vco_now;
    logic          div_start;
    logic [SW-1:0] div_dvd;
    logic          div_busy;
    logic          div_done;
    logic [SW-1:0] quo;
    logic [DW-1:0] rem;
    logic [SW-1:0] fm;
    logic [SW-1:0] diff;
    logic          m_ok;
    logic          adv;
    logic [5:0]    codes;

    always_comb begin
        parent    = q.mode ? DW'(REF_KHZ) : DW'(2 * REF_KHZ);
        fsh       = q.mode ? 4'(FA_B) : 4'(FA_A);
        fmax      = (FA+1)'(1) << fsh;
        vco_now   = VW'(q.tgt) << q.sh;
        div_start = (q.st == S_LAUNCH_M) || (q.st == S_LAUNCH_F);
        div_dvd   = (q.st == S_LAUNCH_F) ? (SW'(q.vco) << fsh) : SW'(vco_now);
        fm        = SW'(q.mc) << fsh;
        diff      = quo - fm;
        m_ok      = q.mode ? ((q.mc >= VW'(M_MIN_B)) && (q.mc <= VW'(M_MAX_B)))
                           : ((q.mc >= VW'(M_MIN_A)) && (q.mc <= VW'(M_MAX_A)));
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        adv    = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.mode = mode;
                    d.tgt  = target_khz;
                    d.sh   = SHW'(ODS);
                    d.st   = S_LAUNCH_M;
                end
            end
            S_LAUNCH_M: begin
                d.vco = vco_now;
                d.st  = S_WAIT_M;
            end
            S_WAIT_M: begin
                if (div_done) begin
                    d.mc = quo[VW-1:0];
                    if (quo == '0) begin
                        adv = 1'b1;
                    end else if (rem == '0) begin
                        d.fc = '0;
                        d.st = S_JUDGE;
                    end else begin
                        d.st = S_LAUNCH_F;
                    end
                end
            end
            S_LAUNCH_F: begin
                d.st = S_WAIT_F;
            end
            S_WAIT_F: begin
                if (div_done) begin
                    if (fm > quo)
                        d.fc = fmax;
                    else if (diff > SW'(fmax - 1'b1))
                        d.fc = fmax - 1'b1;
                    else
                        d.fc = diff[FA:0];
                    d.st = S_JUDGE;
                end
            end
            S_JUDGE: begin
                if (m_ok && (q.fc < fmax)) begin
                    d.done  = 1'b1;
                    d.found = 1'b1;
                    d.m     = q.mc[MW-1:0];
                    d.fr    = q.fc[FA-1:0];
                    d.od    = ODW'(1) << q.sh;
                    d.st    = S_IDLE;
                end else begin
                    adv = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.sh == SHW'(SHMIN)) begin
                d.done  = 1'b1;
                d.found = 1'b0;
                d.m     = '0;
                d.fr    = '0;
                d.od    = '0;
                d.st    = S_IDLE;
            end else begin
                d.sh = q.sh - 1'b1;
                d.st = S_LAUNCH_M;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pll_seq_div #(.N(SW), .D(DW)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (div_dvd),
        .divisor   (parent),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (quo),
        .remainder (rem)
    );

    pll_od_split #(.ODW(ODW)) i_split (
        .od    (q.od),
        .od1   (od1),
        .od2   (od2),
        .od3   (od3),
        .codes (codes)
    );

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign found    = q.found;
    assign mult     = q.m;
    assign frac     = q.fr;
    assign od       = q.od;
    assign od1_code = codes[1:0];
    assign od2_code = codes[3:2];
    assign od3_code = codes[5:4];

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.tgt) && $stable(q.mode)));

    a_r2_div_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy);

    a_r10_hold_mult: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mult) && $stable(frac) && $stable(od) && $stable(found)));

    a_r6_mult_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (q.mode ? (mult >= MW'(M_MIN_B) && mult <= MW'(M_MAX_B))
                                    : (mult >= MW'(M_MIN_A) && mult <= MW'(M_MAX_A))));

    a_r5_frac_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> ({1'b0, frac} < fmax));

    a_r3_od_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> ($onehot(od) && od >= ODW'(OD_MIN)));

    a_r7_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (mult == '0 && od == '0));

endmodule

// File: tb/test_pll_search_engine.sv
module test_pll_search_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [23:0] target_khz = '0;
    logic        busy, done, found;
    logic [7:0]  mult;
    logic [11:0] frac;
    logic [4:0]  od, od1, od2, od3;
    logic [1:0]  od1_code, od2_code, od3_code;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pll_search_engine i_pll_search_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .target_khz(target_khz), .busy(busy), .done(done), .found(found),
        .mult(mult), .frac(frac), .od(od), .od1(od1), .od2(od2), .od3(od3),
        .od1_code(od1_code), .od2_code(od2_code), .od3_code(od3_code)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input bit md, input longint t, output bit ef,
                         output longint em, output longint efr, output longint eod);
        longint vco, m, par, fmx, fr, s;
        bit ok;
        ef = 0; em = 0; efr = 0; eod = 0;
        for (int k = 16; k > 1; k = k >> 1) begin
            vco = t * k;
            m   = md ? vco / 24000 : (vco / 2) / 24000;
            if (m == 0) continue;
            par = md ? 24000 : 48000;
            fmx = md ? 1024 : 4096;
            if ((vco / m == par) && (vco % m == 0)) fr = 0;
            else begin
                s = (vco * fmx) / par;
                if (m * fmx > s) fr = fmx;
                else begin
                    fr = s - m * fmx;
                    if (fr > fmx - 1) fr = fmx - 1;
                end
            end
            ok = md ? (m >= 106 && m <= 247) : (m >= 53 && m <= 123);
            if (ok && fr < fmx) begin
                ef = 1; em = m; efr = fr; eod = k;
                break;
            end
        end
    endtask

    function automatic longint code_of(input longint v);
        case (v)
            1: return 0;
            2: return 1;
            4: return 2;
            8: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check_split(input longint eod);
        longint e1, e2;
        if (eod < 4) begin e1 = 2; e2 = 1; end
        else begin e2 = eod / 4; e1 = eod / e2; end
        chk(od1 == e1, "R8 od1", od1, e1);
        chk(od2 == e2, "R8 od2", od2, e2);
        chk(od3 == 1,  "R8 od3", od3, 1);
        chk(od1_code == code_of(e1), "R9 od1_code", od1_code, code_of(e1));
        chk(od2_code == code_of(e2), "R9 od2_code", od2_code, code_of(e2));
        chk(od3_code == 0, "R9 od3_code", od3_code, 0);
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        if (!seen) chk(0, "R2 done timeout", 0, 1);
    endtask

    task automatic launch(input bit md, input longint t);
        @(negedge clk);
        mode = md; target_khz = 24'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
    endtask

    task automatic compare(input bit md, input longint t);
        bit ef; longint em, efr, eod;
        model(md, t, ef, em, efr, eod);
        chk(found == ef, "R6 found", found, ef);
        chk(mult == em, ef ? "R4 mult" : "R7 mult", mult, em);
        chk(frac == efr, ef ? "R5 frac" : "R7 frac", frac, efr);
        chk(od == eod, ef ? "R3 od" : "R7 od", od, eod);
        check_split(eod);
    endtask

    task automatic run(input bit md, input longint t);
        bit seen;
        logic [7:0] m0; logic [11:0] f0; logic [4:0] o0; logic fd0;
        launch(md, t);
        wait_done(seen);
        if (seen) begin
            compare(md, t);
            m0 = mult; f0 = frac; o0 = od; fd0 = found;
            mode = ~md; target_khz = ~target_khz;
            @(negedge clk);
            chk(done == 1'b0, "R2 done one cycle", done, 0);
            chk(busy == 1'b0, "R2 idle after done", busy, 0);
            repeat (3) @(negedge clk);
            chk(mult == m0 && frac == f0 && od == o0 && found == fd0,
                "R10 hold", {mult, frac, od}, {m0, f0, o0});
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                chk(0, "watchdog", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        bit seen;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R8/R9 split of od = 0
        chk(done == 0 && found == 0, "R1 flags", {done, found}, 0);
        chk(mult == 0 && frac == 0 && od == 0, "R1 results", {mult, frac, od}, 0);
        check_split(0);

        // directed corners
        run(1, 297000);      // R5 exact, od 16
        run(0, 159000);      // R6 lower M bound variant A
        run(0, 158999);      // R7 just below, nothing passes
        run(1, 0);           // R4 every M zero, R7
        run(0, 24'hFFFFFF);  // R6 M too large everywhere
        run(1, 2000000);     // R3 only od 2 passes
        run(1, 1200000);     // R3 od 4
        run(1, 600000);      // R3 od 8
        run(0, 370000);      // R5 fraction, top M variant A
        run(1, 370500);      // R6 upper M bound variant B
        run(1, 371999);      // R5 fraction near clamp
        run(1, 158999);      // R6 below variant B range at od 16

        // R2 start while busy is ignored
        launch(0, 300000);
        repeat (30) @(negedge clk);
        mode = 1'b1; target_khz = 24'd2000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        if (seen) compare(0, 300000);
        begin
            bit extra = 0;
            repeat (600) begin
                @(negedge clk);
                if (done) extra = 1;
            end
            chk(extra == 0, "R2 ignored start gave no second done", extra, 0);
        end

        // random sweep
        for (int i = 0; i < 170; i++) begin
            bit md = 1'($urandom);
            longint t;
            if ($urandom_range(3, 0) != 0) t = $urandom_range(3000000, 150000);
            else                           t = $urandom_range(24'hFFFFFF, 0);
            run(md, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule